// File: doc/BRIEF.md
# Banked Memory Window Decoder

This block stands between a small processor with a 10-bit address bus and a 64 KB physical memory built from one ROM half and one RAM half. It splits the processor's 1 KB view into two 512-byte windows. The lower window shows whichever physical bank the program last selected. The upper window always shows the highest bank, which holds scratch RAM, the I/O ports and the stack. Because the top processor address bit only steers a multiplexer, it never reaches the memory chips. The upper physical address bits come either from a writable bank register or from the fixed common-bank number.

The block also decodes a run of eight memory-mapped I/O port selects inside the common window. Port 0 is the bank register itself, so a program changes the lower window by storing a bank number there. It can read the current number back from the same address. Whether an access goes to ROM or to RAM depends on the physical bank and not on the processor address. Stores that land in ROM are therefore dropped, however the bank was reached.

The processor side is a plain strobe bus with no back-pressure. Every access completes in the cycle it is presented: selects, address and read data are combinational, and a bank register store takes effect at the next clock edge. At most one strobe is active in any cycle.

Top module: `bank_window_decoder`

## Requirements
- R1: After reset the bank register holds bank 0, so a read of processor address 0x000 drives physical address 0x0000 and the bank port reads 0x00.
- R2: When processor address bit 9 is 0, the physical address is the 7-bit bank register value in bits 15:9 and processor address bits 8:0 in bits 8:0.
- R3: When processor address bit 9 is 1, physical address bits 15:9 are 127 (all ones) whatever the bank register holds, so the stack region 0x3C0–0x3FF lands at 0xFFC0–0xFFFF.
- R4: A write strobe at address 0x3B8 (port 0) loads write-data bits 6:0 into the bank register at the next rising clock edge; write-data bit 7 is ignored.
- R5: A read of address 0x3B8 returns the current bank number in bits 6:0 with bit 7 as zero.
- R6: Physical banks 0–63 (physical address bit 15 = 0) are ROM and banks 64–127 are RAM; a read asserts `rom_sel` or `ram_sel` accordingly, never both.
- R7: A write that resolves to a ROM bank asserts none of `rom_sel`, `ram_sel` and `mem_we`.
- R8: A write that resolves to a RAM bank outside the port range asserts both `ram_sel` and `mem_we`.
- R9: Addresses 0x3B8–0x3BF form the port range: a read or write there asserts exactly the `port_sel` bit given by address bits 2:0 and no memory select or write enable.
- R10: Reads in the port range from ports 1–7 return that port's byte from `port_rdata` (port n in bits 8n+7:8n); reads elsewhere return `mem_rdata`.
- R11: With no strobe active, all port and memory selects and the write enable are low and the bank register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 10 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_rdata | output | 8 | Read data returned to the processor |
| mem_addr | output | 16 | Physical memory address |
| mem_rdata | input | 8 | Data from the selected memory chip |
| rom_sel | output | 1 | ROM chip select |
| ram_sel | output | 1 | RAM chip select |
| mem_we | output | 1 | Memory write enable |
| port_sel | output | 8 | One-hot I/O port select |
| port_rdata | input | 64 | Read bytes of the eight ports, port n in bits 8n+7:8n |

## Verification
The properties take for granted that the processor never raises the read and write strobes together. One property watches for a breach of that rule, and the stimulus table holds a single operation per row, so it never creates one. They also take the reset pin as synchronous and hold back while it is low, because the bank register is only defined after an edge with reset asserted. The bench resets during idle cycles only and drives every input at the falling edge, so the combinational outputs settle before they are sampled.

// File: rtl/bsw_pkg.sv
package bsw_pkg;

  // Memory-side control bundle produced by the decoder each cycle.
  typedef struct packed {
    logic rom;
    logic ram;
    logic we;
  } mem_ctl_t;

  // Kind of processor access in the current cycle.
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } access_e;

  function automatic access_e classify(input logic rd, input logic wr);
    if (wr)      return ACC_WRITE;
    else if (rd) return ACC_READ;
    else         return ACC_IDLE;
  endfunction

endpackage

// File: rtl/bsw_bank_reg.sv
module bsw_bank_reg #(
  parameter int DATA_W = 8,
  parameter int BANK_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [BANK_W-1:0] bank_q
);

  logic unused_din;
  assign unused_din = ^din[DATA_W-1:BANK_W];

  always_ff @(posedge clk) begin
    if (!rst_n)    bank_q <= '0;
    else if (load) bank_q <= din[BANK_W-1:0];
  end

endmodule

// File: rtl/bsw_io_decode.sv
module bsw_io_decode #(
  parameter int CPU_AW    = 10,
  parameter int NUM_PORTS = 8,
  parameter int IO_BASE   = 'h3B8,
  localparam int PIDX_W   = $clog2(NUM_PORTS)
) (
  input  logic [CPU_AW-1:0]    addr,
  input  logic                 strobe,
  output logic                 in_window,
  output logic [PIDX_W-1:0]    port_idx,
  output logic [NUM_PORTS-1:0] port_sel
);

  localparam logic [CPU_AW-1:0] BASE_V = CPU_AW'(IO_BASE);

  assign in_window = (addr[CPU_AW-1:PIDX_W] == BASE_V[CPU_AW-1:PIDX_W]);
  assign port_idx  = addr[PIDX_W-1:0];

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_sel
    assign port_sel[i] = strobe && in_window && (port_idx == PIDX_W'(i));
  end

endmodule

// File: rtl/bsw_addr_map.sv
module bsw_addr_map #(
  parameter int CPU_AW  = 10,
  parameter int PHYS_AW = 16,
  localparam int OFF_W  = CPU_AW - 1,
  localparam int BANK_W = PHYS_AW - OFF_W
) (
  input  logic [CPU_AW-1:0]  addr,
  input  logic [BANK_W-1:0]  bank,
  output logic [PHYS_AW-1:0] phys_addr,
  output logic               is_ram
);

  localparam logic [BANK_W-1:0] COMMON_BANK = '1;

  logic [BANK_W-1:0] eff_bank;

  always_comb begin
    eff_bank  = addr[CPU_AW-1] ? COMMON_BANK : bank;
    phys_addr = {eff_bank, addr[OFF_W-1:0]};
    is_ram    = eff_bank[BANK_W-1];
  end

endmodule

// File: rtl/bsw_rdata_mux.sv
module bsw_rdata_mux #(
  parameter int DATA_W    = 8,
  parameter int BANK_W    = 7,
  parameter int NUM_PORTS = 8,
  parameter int BANK_PORT = 0,
  localparam int PIDX_W   = $clog2(NUM_PORTS)
) (
  input  logic [BANK_W-1:0]           bank,
  input  logic [NUM_PORTS*DATA_W-1:0] port_rdata,
  input  logic [DATA_W-1:0]           mem_rdata,
  input  logic                        in_window,
  input  logic [PIDX_W-1:0]           port_idx,
  output logic [DATA_W-1:0]           rdata
);

  logic [DATA_W-1:0] src [NUM_PORTS];
  logic              unused_slot;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_src
    if (i == BANK_PORT) begin : g_bank
      assign src[i] = DATA_W'(bank);
    end else begin : g_ext
      assign src[i] = port_rdata[i*DATA_W +: DATA_W];
    end
  end

  assign unused_slot = ^port_rdata[BANK_PORT*DATA_W +: DATA_W];
  assign rdata       = in_window ? src[port_idx] : mem_rdata;

endmodule

// File: rtl/bank_window_decoder.sv
module bank_window_decoder
  import bsw_pkg::*;
#(
  parameter int CPU_AW    = 10,
  parameter int PHYS_AW   = 16,
  parameter int DATA_W    = 8,
  parameter int NUM_PORTS = 8,
  parameter int IO_BASE   = 'h3B8,
  parameter int BANK_PORT = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CPU_AW-1:0]           cpu_addr,
  input  logic [DATA_W-1:0]           cpu_wdata,
  input  logic                        cpu_rd,
  input  logic                        cpu_wr,
  output logic [DATA_W-1:0]           cpu_rdata,
  output logic [PHYS_AW-1:0]          mem_addr,
  input  logic [DATA_W-1:0]           mem_rdata,
  output logic                        rom_sel,
  output logic                        ram_sel,
  output logic                        mem_we,
  output logic [NUM_PORTS-1:0]        port_sel,
  input  logic [NUM_PORTS*DATA_W-1:0] port_rdata
);

  localparam int OFF_W  = CPU_AW - 1;
  localparam int BANK_W = PHYS_AW - OFF_W;
  localparam int PIDX_W = $clog2(NUM_PORTS);

  logic [BANK_W-1:0] bank_num;
  logic              in_window;
  logic [PIDX_W-1:0] port_idx;
  logic              is_ram;
  logic              bank_load;
  access_e           acc;
  mem_ctl_t          ctl;

  assign acc = classify(cpu_rd, cpu_wr);

  bsw_io_decode #(
    .CPU_AW(CPU_AW), .NUM_PORTS(NUM_PORTS), .IO_BASE(IO_BASE)
  ) u_io (
    .addr(cpu_addr), .strobe(acc != ACC_IDLE),
    .in_window(in_window), .port_idx(port_idx), .port_sel(port_sel)
  );

  assign bank_load = (acc == ACC_WRITE) && in_window && (port_idx == PIDX_W'(BANK_PORT));

  bsw_bank_reg #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .load(bank_load), .din(cpu_wdata), .bank_q(bank_num)
  );

  bsw_addr_map #(.CPU_AW(CPU_AW), .PHYS_AW(PHYS_AW)) u_map (
    .addr(cpu_addr), .bank(bank_num), .phys_addr(mem_addr), .is_ram(is_ram)
  );

  always_comb begin
    ctl = '0;
    if (!in_window) begin
      unique case (acc)
        ACC_READ: begin
          ctl.rom = !is_ram;
          ctl.ram = is_ram;
        end
        ACC_WRITE: begin
          ctl.ram = is_ram;
          ctl.we  = is_ram;
        end
        default: ctl = '0;
      endcase
    end
  end

  assign rom_sel = ctl.rom;
  assign ram_sel = ctl.ram;
  assign mem_we  = ctl.we;

  bsw_rdata_mux #(
    .DATA_W(DATA_W), .BANK_W(BANK_W), .NUM_PORTS(NUM_PORTS), .BANK_PORT(BANK_PORT)
  ) u_rd (
    .bank(bank_num), .port_rdata(port_rdata), .mem_rdata(mem_rdata),
    .in_window(in_window), .port_idx(port_idx), .rdata(cpu_rdata)
  );

endmodule

// File: rtl/bsw_checker.sv
module bsw_checker #(
  parameter int CPU_AW    = 10,
  parameter int PHYS_AW   = 16,
  parameter int DATA_W    = 8,
  parameter int NUM_PORTS = 8,
  parameter int IO_BASE   = 'h3B8,
  parameter int BANK_PORT = 0,
  localparam int OFF_W    = CPU_AW - 1,
  localparam int BANK_W   = PHYS_AW - OFF_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [CPU_AW-1:0]    cpu_addr,
  input logic [DATA_W-1:0]    cpu_wdata,
  input logic                 cpu_rd,
  input logic                 cpu_wr,
  input logic [DATA_W-1:0]    cpu_rdata,
  input logic [PHYS_AW-1:0]   mem_addr,
  input logic                 rom_sel,
  input logic                 ram_sel,
  input logic                 mem_we,
  input logic [NUM_PORTS-1:0] port_sel,
  input logic [BANK_W-1:0]    bank_num
);

  localparam logic [CPU_AW-1:0] BANK_ADDR = CPU_AW'(IO_BASE + BANK_PORT);
  localparam logic [BANK_W-1:0] TOP_BANK  = '1;

  // Input rule the other properties rely on: one strobe per cycle.
  p_one_strobe_in: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_rd && cpu_wr));

  p_bank_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == BANK_ADDR) |=> bank_num == $past(cpu_wdata[BANK_W-1:0]));

  p_bank_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_addr == BANK_ADDR) |=> $stable(bank_num));

  p_common_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[CPU_AW-1] |-> mem_addr[PHYS_AW-1:OFF_W] == TOP_BANK);

  p_one_chip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_sel && ram_sel));

  p_rom_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (ram_sel && cpu_wr && mem_addr[PHYS_AW-1]));

  p_port_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (port_sel != '0) |-> ($countones(port_sel) == 1 && !rom_sel && !ram_sel && !mem_we));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_rd || cpu_wr) |-> (port_sel == '0 && !rom_sel && !ram_sel && !mem_we));

  p_bank_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr == BANK_ADDR) |-> cpu_rdata == DATA_W'(bank_num));

endmodule

bind bank_window_decoder bsw_checker #(
  .CPU_AW(CPU_AW), .PHYS_AW(PHYS_AW), .DATA_W(DATA_W),
  .NUM_PORTS(NUM_PORTS), .IO_BASE(IO_BASE), .BANK_PORT(BANK_PORT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .mem_addr(mem_addr),
  .rom_sel(rom_sel), .ram_sel(ram_sel), .mem_we(mem_we), .port_sel(port_sel),
  .bank_num(bank_num)
);

// File: tb/test_bank_window_decoder.sv
module test_bank_window_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 27;
  // row: op(2) addr(10) wdata(8) exp_addr(16) exp {rom,ram,we}(3) exp_port(8) exp_rdata(8)
  localparam logic [54:0] VEC [NV] = '{
    {2'd1, 10'h000, 8'h00, 16'h0000, 3'b100, 8'h00, 8'hC3}, // R1 R2 R6
    {2'd1, 10'h1FF, 8'h00, 16'h01FF, 3'b100, 8'h00, 8'hC3}, // R2
    {2'd1, 10'h200, 8'h00, 16'hFE00, 3'b010, 8'h00, 8'hC3}, // R3 R6
    {2'd2, 10'h3C0, 8'h11, 16'hFFC0, 3'b011, 8'h00, 8'hC3}, // R3 R8 stack
    {2'd1, 10'h3FF, 8'h00, 16'hFFFF, 3'b010, 8'h00, 8'hC3}, // R3
    {2'd1, 10'h3B8, 8'h00, 16'hFFB8, 3'b000, 8'h01, 8'h00}, // R5 R9
    {2'd1, 10'h3BB, 8'h00, 16'hFFBB, 3'b000, 8'h08, 8'h43}, // R9 R10
    {2'd1, 10'h3BF, 8'h00, 16'hFFBF, 3'b000, 8'h80, 8'h47}, // R9 R10
    {2'd2, 10'h3B8, 8'h85, 16'hFFB8, 3'b000, 8'h01, 8'h00}, // R4
    {2'd1, 10'h3B8, 8'h00, 16'hFFB8, 3'b000, 8'h01, 8'h05}, // R4 bit 7 dropped
    {2'd1, 10'h123, 8'h00, 16'h0B23, 3'b100, 8'h00, 8'hC3}, // R2
    {2'd2, 10'h045, 8'hAA, 16'h0A45, 3'b000, 8'h00, 8'hC3}, // R7
    {2'd0, 10'h045, 8'h00, 16'h0A45, 3'b000, 8'h00, 8'hC3}, // R11
    {2'd2, 10'h3B8, 8'h40, 16'hFFB8, 3'b000, 8'h01, 8'h05}, // R4
    {2'd1, 10'h3B8, 8'h00, 16'hFFB8, 3'b000, 8'h01, 8'h40}, // R5
    {2'd1, 10'h010, 8'h00, 16'h8010, 3'b010, 8'h00, 8'hC3}, // R6 RAM bank
    {2'd2, 10'h1FF, 8'h3C, 16'h81FF, 3'b011, 8'h00, 8'hC3}, // R8
    {2'd1, 10'h250, 8'h00, 16'hFE50, 3'b010, 8'h00, 8'hC3}, // R3
    {2'd2, 10'h3B8, 8'h7F, 16'hFFB8, 3'b000, 8'h01, 8'h40}, // R4
    {2'd1, 10'h000, 8'h00, 16'hFE00, 3'b010, 8'h00, 8'hC3}, // R2 top bank
    {2'd2, 10'h3BD, 8'h99, 16'hFFBD, 3'b000, 8'h20, 8'h45}, // R9 other port
    {2'd1, 10'h3B8, 8'h00, 16'hFFB8, 3'b000, 8'h01, 8'h7F}, // R5 bank kept
    {2'd2, 10'h3B8, 8'h3F, 16'hFFB8, 3'b000, 8'h01, 8'h7F}, // R4
    {2'd1, 10'h1FF, 8'h00, 16'h7FFF, 3'b100, 8'h00, 8'hC3}, // R6 last ROM byte
    {2'd2, 10'h1FF, 8'h55, 16'h7FFF, 3'b000, 8'h00, 8'hC3}, // R7
    {2'd1, 10'h3B7, 8'h00, 16'hFFB7, 3'b010, 8'h00, 8'hC3}, // R9 below range
    {2'd0, 10'h3B8, 8'h00, 16'hFFB8, 3'b000, 8'h00, 8'h3F}  // R11 R10
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_rd, cpu_wr;
  logic [7:0]  cpu_rdata;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        rom_sel, ram_sel, mem_we;
  logic [7:0]  port_sel;
  logic [63:0] port_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar i = 0; i < 8; i++) begin : g_port
    assign port_rdata[i*8 +: 8] = 8'h40 + 8'(i);
  end
  assign mem_rdata = 8'hC3;

  bank_window_decoder i_bank_window_decoder (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .rom_sel(rom_sel),
    .ram_sel(ram_sel), .mem_we(mem_we), .port_sel(port_sel), .port_rdata(port_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_rd    = (op == 2'd1);
    cpu_wr    = (op == 2'd2);
    cpu_addr  = a;
    cpu_wdata = d;
    #(CLK_PERIOD/4);
  endtask

  initial begin
    rst_n = 1'b0; cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R11 reset quiet", {rom_sel, ram_sel, mem_we, port_sel}, '0);
    @(negedge clk) rst_n = 1'b1;
    drive(2'd1, 10'h3B8, 8'h00);
    check("R1 bank after reset", cpu_rdata, 8'h00);
    drive(2'd1, 10'h000, 8'h00);
    check("R1 first bank addr", mem_addr, 16'h0000);

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][54:53], VEC[k][52:43], VEC[k][42:35]);
      check($sformatf("R2/R3 addr row %0d", k), mem_addr, VEC[k][34:19]);
      check($sformatf("R6/R7/R8 ctl row %0d", k), {rom_sel, ram_sel, mem_we}, VEC[k][18:16]);
      check($sformatf("R9 port row %0d", k), port_sel, VEC[k][15:8]);
      check($sformatf("R5/R10 rdata row %0d", k), cpu_rdata, VEC[k][7:0]);
    end

    // R1: reset in mid-run returns the bank to 0 (bank currently 63).
    drive(2'd0, 10'h000, 8'h00);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    drive(2'd1, 10'h3B8, 8'h00);
    check("R1 bank after second reset", cpu_rdata, 8'h00);
    drive(2'd1, 10'h0AB, 8'h00);
    check("R1 window after second reset", mem_addr, 16'h00AB);
    // R4: port 0 reached by write only; a read strobe there leaves the bank alone.
    drive(2'd1, 10'h3B8, 8'h00);
    drive(2'd1, 10'h3B8, 8'h00);
    check("R4 read does not load", cpu_rdata, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule